// File: doc/BRIEF.md
# Multi-Bank Interface Start-Up Coordinator

This block brings up a source-synchronous I/O interface whose pins are spread over several banks, so that every bank leaves reset on the same control-clock edge. In the control clock domain it resynchronizes the lock flag of each bank's PLL and combines the flags into one lock. That lock releases a single reset shared by all per-bank reset sequencers. A common reset request puts every PLL and every sequencer into reset together.

Once the sequencers are released, their done flags are combined into one interface-ready flag. That flag is carried into the application clock domain, where it opens the transmit output drivers and gates the receive FIFO read enable. The read enable comes from the empty flag of one chosen slice, the one at the far end of the clock backbone. It is inverted, registered once, and driven to the read-enable input of every used slice. If any bank loses lock, the shared reset returns and the application side falls back to its idle values.

Top module: `mbb_bringup`

## Requirements
- R1: Each lock input passes through a two-flop synchronizer. With the reset request low, `seq_rst_o` deasserts on the third control-clock edge after the last lock input goes high.
- R2: While any bank's lock input is low, all bits of `seq_rst_o` are 1.
- R3: While `rst_req_i` is high, every bit of `pll_rst_o` and `seq_rst_o` is 1 from the next control-clock edge. `pll_rst_o` returns to 0 one edge after the request falls.
- R4: `intf_rdy_o` is high only when every bit of `seq_done_i` was high at the previous control edge and the shared sequencer reset is released. It is never high while `seq_rst_o` is high.
- R5: `tbyte_o` has 4 bits per bank. All of its bits are 1 (outputs tristated) until interface-ready has crossed into the application domain through two flops. After that, all of its bits are 0.
- R6: Every bit of `fifo_rd_en_o` equals, one application edge later, the inverse of `fifo_empty_i[FAR_IDX]` ANDed with the synchronized ready flag. Empty flags of other slices have no effect.
- R7: After any bank's lock drops, `seq_rst_o` returns to all ones and `intf_rdy_o` falls. In the application domain, `tbyte_o` returns to all ones and `fifo_rd_en_o` to all zeros, whatever the empty flags show.
- R8: While `rst_ni` is low, `pll_rst_o` and `seq_rst_o` are all ones, `intf_rdy_o` is 0, `tbyte_o` is all ones and `fifo_rd_en_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk_i | input | 1 | Control (register-interface) clock |
| app_clk_i | input | 1 | Application clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Common reset request for PLLs and sequencers, control domain |
| pll_locked_i | input | NUM_BANKS | Per-bank PLL lock, asynchronous |
| pll_rst_o | output | NUM_BANKS | Per-bank PLL reset |
| seq_rst_o | output | NUM_BANKS | Shared reset to the per-bank sequencers |
| seq_done_i | input | NUM_BANKS | Per-bank sequence-done flags, control domain |
| intf_rdy_o | output | 1 | Combined interface-ready, control domain |
| tbyte_o | output | 4*NUM_BANKS | Transmit tristate-enable, application domain |
| fifo_empty_i | input | NUM_SLICES | Receive FIFO empty flags, application domain |
| fifo_rd_en_o | output | NUM_SLICES | Receive FIFO read enable to every used slice |

## Verification
Banks lock one at a time in a random order. This separates an AND of all lock flags from an OR or from a single bank, and the release edge is counted exactly. Sequence-done flags arrive partially before they arrive complete, so an early ready shows up. Random empty vectors in which the selected slice and the other slices differ show whether the read enable tracks the wrong slice. Random rounds of lock drops, reset requests and done patterns are compared with a settled model, which catches a gate missing on either clock domain.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  localparam int unsigned TRI_W    = 4;
  localparam int unsigned SYNC_LEN = 2;
endpackage

// File: rtl/mbb_sync.sv
module mbb_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mbb_ctl.sv
module mbb_ctl #(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rst_req_i,
  input  logic [NUM_BANKS-1:0] pll_locked_i,
  input  logic [NUM_BANKS-1:0] seq_done_i,
  output logic [NUM_BANKS-1:0] pll_rst_o,
  output logic [NUM_BANKS-1:0] seq_rst_o,
  output logic                 rdy_o
);
  logic [NUM_BANKS-1:0] lock_s;
  logic lock_all, seq_rst_d, seq_rst_q, pll_rst_q, rdy_q;

  mbb_sync #(.WIDTH(NUM_BANKS), .STAGES(mbb_pkg::SYNC_LEN)) u_lock_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pll_locked_i),
    .q_o   (lock_s)
  );

  assign lock_all  = &lock_s;
  assign seq_rst_d = rst_req_i | ~lock_all;

  // ready and sequencer reset update on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_rst_q <= 1'b1;
      seq_rst_q <= 1'b1;
      rdy_q     <= 1'b0;
    end else begin
      pll_rst_q <= rst_req_i;
      seq_rst_q <= seq_rst_d;
      rdy_q     <= (&seq_done_i) & ~seq_rst_d;
    end
  end

  assign pll_rst_o = {NUM_BANKS{pll_rst_q}};
  assign seq_rst_o = {NUM_BANKS{seq_rst_q}};
  assign rdy_o     = rdy_q;
endmodule

// File: rtl/mbb_app.sv
module mbb_app #(
  parameter int unsigned NUM_BANKS  = 2,
  parameter int unsigned NUM_SLICES = 8,
  parameter int unsigned FAR_IDX    = 7,
  localparam int unsigned TB_W = mbb_pkg::TRI_W * NUM_BANKS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rdy_async_i,
  input  logic [NUM_SLICES-1:0] fifo_empty_i,
  output logic [TB_W-1:0]       tbyte_o,
  output logic [NUM_SLICES-1:0] fifo_rd_en_o
);
  logic rdy_s, rd_en_q;

  mbb_sync #(.WIDTH(1), .STAGES(mbb_pkg::SYNC_LEN)) u_rdy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rdy_async_i),
    .q_o   (rdy_s)
  );

  // far-end slice empty flag, registered once, fanned out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_en_q <= 1'b0;
    else         rd_en_q <= rdy_s & ~fifo_empty_i[FAR_IDX];
  end

  assign tbyte_o      = {TB_W{~rdy_s}};
  assign fifo_rd_en_o = {NUM_SLICES{rd_en_q}};
endmodule

// File: rtl/mbb_bringup.sv
module mbb_bringup #(
  parameter int unsigned NUM_BANKS  = 2,
  parameter int unsigned NUM_SLICES = 8,
  parameter int unsigned FAR_IDX    = 7,
  localparam int unsigned TB_W = mbb_pkg::TRI_W * NUM_BANKS
) (
  input  logic                  ctl_clk_i,
  input  logic                  app_clk_i,
  input  logic                  rst_ni,
  input  logic                  rst_req_i,
  input  logic [NUM_BANKS-1:0]  pll_locked_i,
  output logic [NUM_BANKS-1:0]  pll_rst_o,
  output logic [NUM_BANKS-1:0]  seq_rst_o,
  input  logic [NUM_BANKS-1:0]  seq_done_i,
  output logic                  intf_rdy_o,
  output logic [TB_W-1:0]       tbyte_o,
  input  logic [NUM_SLICES-1:0] fifo_empty_i,
  output logic [NUM_SLICES-1:0] fifo_rd_en_o
);
  logic rdy_ctl;

  mbb_ctl #(.NUM_BANKS(NUM_BANKS)) u_ctl (
    .clk_i       (ctl_clk_i),
    .rst_ni      (rst_ni),
    .rst_req_i   (rst_req_i),
    .pll_locked_i(pll_locked_i),
    .seq_done_i  (seq_done_i),
    .pll_rst_o   (pll_rst_o),
    .seq_rst_o   (seq_rst_o),
    .rdy_o       (rdy_ctl)
  );

  mbb_app #(.NUM_BANKS(NUM_BANKS), .NUM_SLICES(NUM_SLICES), .FAR_IDX(FAR_IDX)) u_app (
    .clk_i       (app_clk_i),
    .rst_ni      (rst_ni),
    .rdy_async_i (rdy_ctl),
    .fifo_empty_i(fifo_empty_i),
    .tbyte_o     (tbyte_o),
    .fifo_rd_en_o(fifo_rd_en_o)
  );

  assign intf_rdy_o = rdy_ctl;
endmodule

// File: rtl/mbb_checker.sv
module mbb_checker #(
  parameter int unsigned NUM_BANKS  = 2,
  parameter int unsigned NUM_SLICES = 8,
  parameter int unsigned FAR_IDX    = 7,
  localparam int unsigned TB_W = mbb_pkg::TRI_W * NUM_BANKS
) (
  input logic                  ctl_clk_i,
  input logic                  app_clk_i,
  input logic                  rst_ni,
  input logic                  rst_req_i,
  input logic [NUM_BANKS-1:0]  pll_locked_i,
  input logic [NUM_BANKS-1:0]  pll_rst_o,
  input logic [NUM_BANKS-1:0]  seq_rst_o,
  input logic [NUM_BANKS-1:0]  seq_done_i,
  input logic                  intf_rdy_o,
  input logic [TB_W-1:0]       tbyte_o,
  input logic [NUM_SLICES-1:0] fifo_empty_i,
  input logic [NUM_SLICES-1:0] fifo_rd_en_o
);
  a_r1_release_after_sync: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
    $fell(seq_rst_o[0]) |-> $past(&pll_locked_i, 2));

  a_r3_req_resets_all: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
    rst_req_i |=> (&pll_rst_o && &seq_rst_o));

  a_r4_rdy_not_in_reset: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
    (|seq_rst_o) |-> !intf_rdy_o);

  a_r4_rdy_needs_done: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
    intf_rdy_o |-> $past(&seq_done_i));

  a_r6_rd_en_gated: assert property (@(posedge app_clk_i) disable iff (!rst_ni)
    (|fifo_rd_en_o) |-> ($past(tbyte_o == '0) && $past(!fifo_empty_i[FAR_IDX])));
endmodule

bind mbb_bringup mbb_checker #(
  .NUM_BANKS(NUM_BANKS), .NUM_SLICES(NUM_SLICES), .FAR_IDX(FAR_IDX)
) u_chk (.*);

// File: tb/tb_mbb_bringup.sv
`timescale 1ns/1ps
module tb_mbb_bringup;
  localparam int NB = 3;
  localparam int NS = 8;
  localparam int FAR = 5;
  localparam int TW = 4 * NB;

  logic ctl_clk = 1'b0, app_clk = 1'b0, rst_n = 1'b0;
  logic rst_req = 1'b0;
  logic [NB-1:0] locked = '0, done = '0;
  logic [NS-1:0] empty = '1;
  logic [NB-1:0] pll_rst, seq_rst;
  logic intf_rdy;
  logic [TW-1:0] tbyte;
  logic [NS-1:0] rd_en;
  int n_run = 0, n_fail = 0;

  always #2.5 ctl_clk = ~ctl_clk;
  initial begin #4; forever #4 app_clk = ~app_clk; end

  mbb_bringup #(.NUM_BANKS(NB), .NUM_SLICES(NS), .FAR_IDX(FAR)) dut (
    .ctl_clk_i(ctl_clk), .app_clk_i(app_clk), .rst_ni(rst_n), .rst_req_i(rst_req),
    .pll_locked_i(locked), .pll_rst_o(pll_rst), .seq_rst_o(seq_rst),
    .seq_done_i(done), .intf_rdy_o(intf_rdy), .tbyte_o(tbyte),
    .fifo_empty_i(empty), .fifo_rd_en_o(rd_en));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic f_seq_rst(logic req, logic [NB-1:0] lk);
    return req | ~(&lk);
  endfunction
  function automatic logic f_rdy(logic req, logic [NB-1:0] lk, logic [NB-1:0] dn);
    return (&dn) & ~f_seq_rst(req, lk);
  endfunction
  function automatic logic [TW-1:0] f_tbyte(logic r);
    return r ? '0 : '1;
  endfunction
  function automatic logic [NS-1:0] f_rd(logic r, logic [NS-1:0] e);
    return (r & ~e[FAR]) ? '1 : '0;
  endfunction

  task automatic ctl_step(int n); repeat (n) @(posedge ctl_clk); #1; endtask
  task automatic app_step(int n); repeat (n) @(posedge app_clk); #1; endtask
  task automatic drive_edge; @(negedge ctl_clk); endtask
  task automatic settle; ctl_step(8); app_step(5); endtask

  task automatic chk_all(input string tag);
    logic r;
    r = f_rdy(rst_req, locked, done);
    chk(seq_rst == {NB{f_seq_rst(rst_req, locked)}}, {tag, " R2 seq_rst"}, 64'(seq_rst), 64'({NB{f_seq_rst(rst_req, locked)}}));
    chk(pll_rst == {NB{rst_req}}, {tag, " R3 pll_rst"}, 64'(pll_rst), 64'({NB{rst_req}}));
    chk(intf_rdy == r, {tag, " R4 intf_rdy"}, 64'(intf_rdy), 64'(r));
    chk(tbyte == f_tbyte(r), {tag, " R5 tbyte"}, 64'(tbyte), 64'(f_tbyte(r)));
    chk(rd_en == f_rd(r, empty), {tag, " R6 rd_en"}, 64'(rd_en), 64'(f_rd(r, empty)));
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed_v;
    int order [NB];
    seed_v = $urandom(32'd4242);
    // R8 reset state
    #12;
    chk(pll_rst == '1, "R8 pll_rst", 64'(pll_rst), '1);
    chk(seq_rst == '1, "R8 seq_rst", 64'(seq_rst), '1);
    chk(intf_rdy == 1'b0, "R8 intf_rdy", 64'(intf_rdy), 0);
    chk(tbyte == '1, "R8 tbyte", 64'(tbyte), 64'({TW{1'b1}}));
    chk(rd_en == '0, "R8 rd_en", 64'(rd_en), 0);
    drive_edge; rst_n = 1'b1; rst_req = 1'b1;
    ctl_step(3);
    chk(&pll_rst && &seq_rst, "R3 request holds resets", 64'({pll_rst, seq_rst}), 64'({2*NB{1'b1}}));
    drive_edge; rst_req = 1'b0;
    ctl_step(1);
    chk(pll_rst == '0, "R3 pll_rst release", 64'(pll_rst), 0);
    // locks arrive one by one in random order: R2 then R1 latency
    for (int i = 0; i < NB; i++) order[i] = i;
    for (int i = NB - 1; i > 0; i--) begin
      int j, t;
      j = int'($urandom_range(i, 0)); t = order[i]; order[i] = order[j]; order[j] = t;
    end
    for (int i = 0; i < NB - 1; i++) begin
      drive_edge; locked[order[i]] = 1'b1;
      ctl_step(5);
      chk(seq_rst == '1, "R2 partial lock keeps reset", 64'(seq_rst), 64'({NB{1'b1}}));
    end
    drive_edge; locked[order[NB-1]] = 1'b1;
    ctl_step(2);
    chk(seq_rst == '1, "R1 still in reset at edge 2", 64'(seq_rst), 64'({NB{1'b1}}));
    ctl_step(1);
    chk(seq_rst == '0, "R1 released at edge 3", 64'(seq_rst), 0);
    // R4 partial done
    drive_edge; done = NB'(1);
    ctl_step(3);
    chk(intf_rdy == 1'b0, "R4 partial done", 64'(intf_rdy), 0);
    app_step(4);
    chk(tbyte == '1, "R5 tristated before ready", 64'(tbyte), 64'({TW{1'b1}}));
    drive_edge; done = '1; empty = '0;
    ctl_step(1);
    chk(intf_rdy == 1'b1, "R4 all done", 64'(intf_rdy), 1);
    app_step(4);
    chk(tbyte == '0, "R5 enabled after crossing", 64'(tbyte), 0);
    // R6 random empties, others differ from far slice
    for (int k = 0; k < 40; k++) begin
      drive_edge; empty = NS'($urandom);
      if (k % 4 == 0) empty = ~(NS'(1) << FAR);
      if (k % 4 == 1) empty = NS'(1) << FAR;
      app_step(2);
      chk(rd_en == f_rd(1'b1, empty), "R6 rd_en follows far slice", 64'(rd_en), 64'(f_rd(1'b1, empty)));
    end
    // R7 lock drop
    drive_edge; empty = '0; locked[NB-1] = 1'b0;
    ctl_step(3);
    chk(seq_rst == '1, "R7 seq_rst back", 64'(seq_rst), 64'({NB{1'b1}}));
    chk(intf_rdy == 1'b0, "R7 ready falls", 64'(intf_rdy), 0);
    app_step(4);
    chk(tbyte == '1, "R7 tbyte idle", 64'(tbyte), 64'({TW{1'b1}}));
    chk(rd_en == '0, "R7 rd_en idle with data", 64'(rd_en), 0);
    drive_edge; locked = '1;
    settle; chk_all("directed relock");
    // random rounds
    for (int k = 0; k < 30; k++) begin
      drive_edge;
      locked  = ($urandom_range(2, 0) == 0) ? NB'($urandom) : '1;
      done    = ($urandom_range(2, 0) == 0) ? NB'($urandom) : '1;
      rst_req = ($urandom_range(4, 0) == 0);
      empty   = NS'($urandom);
      settle;
      chk_all("random");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule